// File: doc/BRIEF.md
# Access Permission and Key Checker

This block sits at the end of an address-translation walk. It takes the permission bits already combined across all levels of the walk, the leaf entry's protection key, and the details of the access that triggered the walk. The access details are its kind (load, store or fetch) and its privilege. It also takes the mode controls and two protection-key registers, one for user pages and one for supervisor pages. From these it decides whether the access may proceed.

For an allowed access it returns the final read/write/execute set that a translation cache may record. For a denied access it returns a page-fault error code and flags a reserved-bit violation when that is the cause. Results are captured into registers on a one-cycle valid strobe.

When several faults apply, a fixed priority picks one cause. The order is not-present, reserved bits, the user/supervisor check, the key check, then the general permission check. Only the winning cause is encoded; the write, user and instruction qualifiers are added to every fault code.

Top module: `perm_key_check`

## Requirements
- R1: Every result output is registered. `valid_o` is high exactly one cycle after a cycle with `valid_i` high. On cycles without `valid_i`, `allow_o`, `perm_o`, `err_o` and `rsvd_o` hold their previous values. Reset clears all outputs to zero.
- R2: A not-present input denies the access. Its error code has bit 0 (protection) clear and bit 3 clear, and `rsvd_o` is 0.
- R3: A present entry with `rsvd_i` high, or with the no-execute bit set while `nxe_en_i` is low, is a reserved-bit fault. It sets error bit 3, leaves bit 0 clear and drives `rsvd_o` high.
- R4: A user access (`user_i`=1) to a page whose combined user bit is clear is a protection fault: error bit 0 is set.
- R5: Read is granted unless the access is supervisor-level with `sap_en_i` high on a user page. Write needs read plus either the combined RW bit, or a supervisor access with `wp_en_i` low.
- R6: Execute needs the effective no-execute bit clear. The effective bit is the page's no-execute bit when `nxe_en_i` is high, and 0 otherwise. For a supervisor access it also needs `sxp_en_i` low or a non-user page.
- R7: The key register is `ukey_i` for user pages when `ukey_en_i` is high, and `skey_i` for supervisor pages when `skey_en_i` is high. Otherwise the register is zero. A zero register skips the key check.
- R8: For key k, register bit 2k (access-disable) removes read and write. Bit 2k+1 (write-disable) removes write only when the access is user-level or `wp_en_i` is high.
- R9: A load or store denied by the key mask sets error bits 5 and 0. A fetch never raises this fault.
- R10: The error code qualifiers are added to every fault. Bit 1 is set for stores (`acc_i`=1). Bit 2 is set for user accesses. Bit 4 is set for fetches (`acc_i`=2) when `nxe_en_i` or `sxp_en_i` is high. A load is `acc_i`=0.
- R11: An allowed access gives `allow_o`=1, `err_o`=0 and `perm_o` = final mask (bit 0 read, bit 1 write, bit 2 execute). A denied access gives `allow_o`=0 and `perm_o`=0.
- R12: When several faults apply, the code encodes only the highest-priority one. The order is not-present, reserved, user/supervisor, key, then general permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Check strobe |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| user_i | input | 1 | Access is user-level |
| present_i | input | 1 | Leaf entry present |
| rsvd_i | input | 1 | Walk found reserved bits set |
| pg_rw_i | input | 1 | Combined writable bit |
| pg_us_i | input | 1 | Combined user-page bit |
| pg_xd_i | input | 1 | Combined no-execute bit |
| key_i | input | KEY_W | Leaf protection key |
| nxe_en_i | input | 1 | No-execute enabled |
| sap_en_i | input | 1 | Supervisor access prevention |
| sxp_en_i | input | 1 | Supervisor execution prevention |
| wp_en_i | input | 1 | Supervisor write protect |
| ukey_en_i | input | 1 | User keys enabled |
| skey_en_i | input | 1 | Supervisor keys enabled |
| ukey_i | input | 2*2**KEY_W | User key register |
| skey_i | input | 2*2**KEY_W | Supervisor key register |
| valid_o | output | 1 | Result strobe |
| allow_o | output | 1 | Access allowed |
| perm_o | output | 3 | Final permission set |
| err_o | output | 6 | Page-fault error code |
| rsvd_o | output | 1 | Reserved-bit violation |

## Verification
The bench targets cases where faults overlap. One is a user access to a supervisor page that is also key-blocked; a wrong priority would report the key bit instead of the user/supervisor cause. Another is a reserved fault on a user-mismatched page, which must carry only bit 3 and the qualifiers.

It drives a fetch through an access-disabled key. A design that applied the key check to fetches would fault there, or would drop execute from the permission set. It checks that write-disable spares supervisor writes while write protect is off. It checks that the instruction bit appears only when no-execute or execution prevention is on. It checks that a no-execute bit with no-execute disabled is treated as reserved rather than as a plain execute denial.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_BITS = 3;

  localparam int ERR_P   = 0;
  localparam int ERR_W   = 1;
  localparam int ERR_U   = 2;
  localparam int ERR_RSV = 3;
  localparam int ERR_I   = 4;
  localparam int ERR_K   = 5;
  localparam int ERR_BITS = 6;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_ABSENT,
    CAUSE_RSVD,
    CAUSE_USR,
    CAUSE_KEY,
    CAUSE_PERM
  } cause_e;
endpackage

// File: rtl/pkc_base_perm.sv
module pkc_base_perm
  import pkc_pkg::*;
(
  input  logic                 user_i,
  input  logic                 pg_rw_i,
  input  logic                 pg_us_i,
  input  logic                 pg_xd_i,
  input  logic                 nxe_en_i,
  input  logic                 sap_en_i,
  input  logic                 sxp_en_i,
  input  logic                 wp_en_i,
  output logic [PERM_BITS-1:0] perm_o,
  output logic                 usr_fault_o
);
  logic rd, xd_eff;

  always_comb begin
    xd_eff      = pg_xd_i & nxe_en_i;
    rd          = ~(~user_i & sap_en_i & pg_us_i);
    usr_fault_o = user_i & ~pg_us_i;
    perm_o         = '0;
    perm_o[PERM_R] = rd;
    perm_o[PERM_W] = rd & (pg_rw_i | ~(user_i | wp_en_i));
    perm_o[PERM_X] = ~xd_eff & (user_i | ~(sxp_en_i & pg_us_i));
  end
endmodule

// File: rtl/pkc_key_mask.sv
module pkc_key_mask
  import pkc_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int NKEY   = 1 << KEY_W,
  localparam int KREG_W = 2 * NKEY
) (
  input  logic                 user_i,
  input  logic                 wp_en_i,
  input  logic                 pg_us_i,
  input  logic [KEY_W-1:0]     key_i,
  input  logic                 ukey_en_i,
  input  logic                 skey_en_i,
  input  logic [KREG_W-1:0]    ukey_i,
  input  logic [KREG_W-1:0]    skey_i,
  output logic                 active_o,
  output logic [PERM_BITS-1:0] mask_o
);
  logic [KREG_W-1:0] kreg;
  logic [NKEY-1:0]   ad_vec, wd_vec;
  logic              ad, wd;

  always_comb begin
    if (pg_us_i) kreg = ukey_en_i ? ukey_i : '0;
    else         kreg = skey_en_i ? skey_i : '0;
  end

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    assign ad_vec[g] = kreg[2*g];
    assign wd_vec[g] = kreg[2*g+1];
  end

  always_comb begin
    ad       = ad_vec[key_i];
    wd       = wd_vec[key_i];
    active_o = |kreg;
    mask_o         = '1;
    mask_o[PERM_R] = ~ad;
    mask_o[PERM_W] = ~ad & ~(wd & (user_i | wp_en_i));
  end
endmodule

// File: rtl/pkc_fault_enc.sv
module pkc_fault_enc
  import pkc_pkg::*;
(
  input  logic                present_i,
  input  logic                rsvd_i,
  input  logic                usr_fault_i,
  input  logic                key_fault_i,
  input  logic                perm_fault_i,
  input  acc_e                acc_i,
  input  logic                user_i,
  input  logic                nxe_en_i,
  input  logic                sxp_en_i,
  output logic                allow_o,
  output logic [ERR_BITS-1:0] err_o
);
  cause_e cause;

  always_comb begin
    if (!present_i)        cause = CAUSE_ABSENT;
    else if (rsvd_i)       cause = CAUSE_RSVD;
    else if (usr_fault_i)  cause = CAUSE_USR;
    else if (key_fault_i)  cause = CAUSE_KEY;
    else if (perm_fault_i) cause = CAUSE_PERM;
    else                   cause = CAUSE_NONE;
  end

  always_comb begin
    allow_o = (cause == CAUSE_NONE);
    err_o   = '0;
    unique case (cause)
      CAUSE_RSVD:            err_o[ERR_RSV] = 1'b1;
      CAUSE_USR, CAUSE_PERM: err_o[ERR_P]   = 1'b1;
      CAUSE_KEY: begin
        err_o[ERR_P] = 1'b1;
        err_o[ERR_K] = 1'b1;
      end
      default: ;
    endcase
    if (!allow_o) begin
      err_o[ERR_W] = (acc_i == ACC_STORE);
      err_o[ERR_U] = user_i;
      err_o[ERR_I] = (acc_i == ACC_FETCH) & (nxe_en_i | sxp_en_i);
    end
  end
endmodule

// File: rtl/perm_key_check.sv
module perm_key_check
  import pkc_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int KREG_W = 2 * (1 << KEY_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           acc_i,
  input  logic                 user_i,
  input  logic                 present_i,
  input  logic                 rsvd_i,
  input  logic                 pg_rw_i,
  input  logic                 pg_us_i,
  input  logic                 pg_xd_i,
  input  logic [KEY_W-1:0]     key_i,
  input  logic                 nxe_en_i,
  input  logic                 sap_en_i,
  input  logic                 sxp_en_i,
  input  logic                 wp_en_i,
  input  logic                 ukey_en_i,
  input  logic                 skey_en_i,
  input  logic [KREG_W-1:0]    ukey_i,
  input  logic [KREG_W-1:0]    skey_i,
  output logic                 valid_o,
  output logic                 allow_o,
  output logic [PERM_BITS-1:0] perm_o,
  output logic [ERR_BITS-1:0]  err_o,
  output logic                 rsvd_o
);
  acc_e                 acc;
  logic [PERM_BITS-1:0] base_perm, key_mask, fin_perm;
  logic                 usr_fault, key_act, key_fault, perm_fault, rsvd_any;
  logic                 allow_d;
  logic [ERR_BITS-1:0]  err_d;
  logic                 req_base, req_key;

  assign acc = acc_e'(acc_i);

  pkc_base_perm u_base (
    .user_i     (user_i),
    .pg_rw_i    (pg_rw_i),
    .pg_us_i    (pg_us_i),
    .pg_xd_i    (pg_xd_i),
    .nxe_en_i   (nxe_en_i),
    .sap_en_i   (sap_en_i),
    .sxp_en_i   (sxp_en_i),
    .wp_en_i    (wp_en_i),
    .perm_o     (base_perm),
    .usr_fault_o(usr_fault)
  );

  pkc_key_mask #(.KEY_W(KEY_W)) u_key (
    .user_i   (user_i),
    .wp_en_i  (wp_en_i),
    .pg_us_i  (pg_us_i),
    .key_i    (key_i),
    .ukey_en_i(ukey_en_i),
    .skey_en_i(skey_en_i),
    .ukey_i   (ukey_i),
    .skey_i   (skey_i),
    .active_o (key_act),
    .mask_o   (key_mask)
  );

  always_comb begin
    fin_perm = key_act ? (base_perm & key_mask) : base_perm;
    unique case (acc)
      ACC_STORE: begin req_base = fin_perm[PERM_W]; req_key = key_mask[PERM_W]; end
      ACC_FETCH: begin req_base = fin_perm[PERM_X]; req_key = 1'b1;             end
      default:   begin req_base = fin_perm[PERM_R]; req_key = key_mask[PERM_R]; end
    endcase
    key_fault  = key_act & ~req_key;
    perm_fault = ~req_base;
    rsvd_any   = rsvd_i | (pg_xd_i & ~nxe_en_i);
  end

  pkc_fault_enc u_enc (
    .present_i   (present_i),
    .rsvd_i      (rsvd_any),
    .usr_fault_i (usr_fault),
    .key_fault_i (key_fault),
    .perm_fault_i(perm_fault),
    .acc_i       (acc),
    .user_i      (user_i),
    .nxe_en_i    (nxe_en_i),
    .sxp_en_i    (sxp_en_i),
    .allow_o     (allow_d),
    .err_o       (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      allow_o <= 1'b0;
      perm_o  <= '0;
      err_o   <= '0;
      rsvd_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        allow_o <= allow_d;
        perm_o  <= allow_d ? fin_perm : '0;
        err_o   <= err_d;
        rsvd_o  <= present_i & rsvd_any;
      end
    end
  end
endmodule

// File: rtl/perm_key_check_chk.sv
module perm_key_check_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [1:0] acc_i,
  input logic       present_i,
  input logic       pg_xd_i,
  input logic       nxe_en_i,
  input logic       valid_o,
  input logic       allow_o,
  input logic [2:0] perm_o,
  input logic [5:0] err_o,
  input logic       rsvd_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(err_o) && $stable(perm_o) && $stable(allow_o)); // R1
  AST_ABSENT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !present_i) |=> !allow_o && !err_o[0] && !err_o[3] && !rsvd_o); // R2
  AST_XD_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && present_i && pg_xd_i && !nxe_en_i) |=> rsvd_o && err_o[3] && !err_o[0]); // R3
  AST_FETCH_NO_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_i == 2'd2) |=> !err_o[5]); // R9
  AST_STORE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_i == 2'd1) |=> (allow_o || err_o[1])); // R10
  AST_ALLOW_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && allow_o) |-> (err_o == 6'd0)); // R11
  AST_DENY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !allow_o) |-> (perm_o == 3'd0)); // R11
  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(err_o[3] && err_o[0])); // R12
endmodule

bind perm_key_check perm_key_check_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .acc_i    (acc_i),
  .present_i(present_i),
  .pg_xd_i  (pg_xd_i),
  .nxe_en_i (nxe_en_i),
  .valid_o  (valid_o),
  .allow_o  (allow_o),
  .perm_o   (perm_o),
  .err_o    (err_o),
  .rsvd_o   (rsvd_o)
);

// File: tb/sim_perm_key_check.sv
module sim_perm_key_check;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_W = 4;
  localparam int KREG_W = 2 * (1 << KEY_W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid, user, present, rsvd, rw, us, xd;
  logic nxe, sap, sxp, wp, uken, sken;
  logic [1:0] acc;
  logic [KEY_W-1:0] key;
  logic [KREG_W-1:0] ukey, skey;
  logic valid_o, allow_o, rsvd_o;
  logic [2:0] perm_o;
  logic [5:0] err_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_key_check #(.KEY_W(KEY_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .acc_i(acc), .user_i(user),
    .present_i(present), .rsvd_i(rsvd), .pg_rw_i(rw), .pg_us_i(us), .pg_xd_i(xd),
    .key_i(key), .nxe_en_i(nxe), .sap_en_i(sap), .sxp_en_i(sxp), .wp_en_i(wp),
    .ukey_en_i(uken), .skey_en_i(sken), .ukey_i(ukey), .skey_i(skey),
    .valid_o(valid_o), .allow_o(allow_o), .perm_o(perm_o), .err_o(err_o), .rsvd_o(rsvd_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    valid = 0; acc = 2'd0; user = 0; present = 1; rsvd = 0; rw = 1; us = 1; xd = 0;
    nxe = 0; sap = 0; sxp = 0; wp = 0; uken = 0; sken = 0; key = '0; ukey = '0; skey = '0;
  endtask

  // issue one strobe, sample result at the following negedge
  task automatic fire();
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic a, input logic [2:0] p,
                            input logic [5:0] e, input logic r);
    chk({tag, " valid"}, 32'(valid_o), 32'd1);
    chk({tag, " allow"}, 32'(allow_o), 32'(a));
    chk({tag, " perm"},  32'(perm_o),  32'(p));
    chk({tag, " err"},   32'(err_o),   32'(e));
    chk({tag, " rsvd"},  32'(rsvd_o),  32'(r));
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 32'(valid_o), 0);
    chk("R1 reset allow", 32'(allow_o), 0);
    chk("R1 reset perm",  32'(perm_o), 0);
    chk("R1 reset err",   32'(err_o), 0);
  endtask

  task automatic t_absent();
    defaults(); present = 0; user = 1; acc = 2'd1; fire();
    expect_res("R2 absent user store", 0, 3'd0, 6'h06, 0);
    defaults(); present = 0; acc = 2'd2; nxe = 1; rsvd = 1; fire();
    expect_res("R2 absent fetch", 0, 3'd0, 6'h10, 0);
  endtask

  task automatic t_rsvd();
    defaults(); xd = 1; fire();
    expect_res("R3 xd without nxe", 0, 3'd0, 6'h08, 1);
    defaults(); rsvd = 1; user = 1; us = 0; fire();
    expect_res("R12 rsvd over usr", 0, 3'd0, 6'h0C, 1);
  endtask

  task automatic t_usr();
    defaults(); user = 1; us = 0; fire();
    expect_res("R4 user on sup page", 0, 3'd0, 6'h05, 0);
    defaults(); user = 1; us = 0; uken = 1; sken = 1; skey = '1; fire();
    expect_res("R12 usr over key", 0, 3'd0, 6'h05, 0);
  endtask

  task automatic t_rw();
    defaults(); rw = 0; fire();
    expect_res("R5 sup write wp off", 1, 3'd7, 6'h00, 0);
    defaults(); rw = 0; wp = 1; fire();
    expect_res("R5 sup wp load", 1, 3'd5, 6'h00, 0);
    defaults(); rw = 0; wp = 1; acc = 2'd1; fire();
    expect_res("R5 sup wp store", 0, 3'd0, 6'h03, 0);
    defaults(); sap = 1; fire();
    expect_res("R5 sap user page", 0, 3'd0, 6'h01, 0);
    defaults(); sap = 1; us = 0; fire();
    expect_res("R5 sap sup page", 1, 3'd7, 6'h00, 0);
    defaults(); user = 1; rw = 0; acc = 2'd1; fire();
    expect_res("R5 user store ro", 0, 3'd0, 6'h07, 0);
  endtask

  task automatic t_exec();
    defaults(); nxe = 1; xd = 1; user = 1; acc = 2'd2; fire();
    expect_res("R6 xd fetch", 0, 3'd0, 6'h15, 0);
    defaults(); sxp = 1; acc = 2'd2; fire();
    expect_res("R6 sxp user page", 0, 3'd0, 6'h11, 0);
    defaults(); sxp = 1; us = 0; acc = 2'd2; fire();
    expect_res("R6 sxp sup page", 1, 3'd7, 6'h00, 0);
    defaults(); sxp = 1; acc = 2'd0; fire();
    expect_res("R6 sxp load ok", 1, 3'd3, 6'h00, 0);
    defaults(); nxe = 1; xd = 1; fire();
    expect_res("R6 xd load", 1, 3'd3, 6'h00, 0);
    defaults(); us = 0; user = 1; acc = 2'd2; fire();
    expect_res("R10 fetch no I", 0, 3'd0, 6'h05, 0);
  endtask

  task automatic t_key();
    defaults(); user = 1; uken = 1; key = 4'd3; ukey[6] = 1'b1; fire();
    expect_res("R9 key ad load", 0, 3'd0, 6'h25, 0);
    defaults(); user = 1; uken = 1; key = 4'd3; ukey[7] = 1'b1; acc = 2'd1; fire();
    expect_res("R9 key wd store", 0, 3'd0, 6'h27, 0);
    defaults(); user = 1; uken = 1; key = 4'd3; ukey[7] = 1'b1; fire();
    expect_res("R8 key wd load", 1, 3'd5, 6'h00, 0);
    defaults(); user = 1; uken = 1; key = 4'd3; ukey[6] = 1'b1; acc = 2'd2; fire();
    expect_res("R9 fetch with ad", 1, 3'd4, 6'h00, 0);
    defaults(); user = 1; uken = 0; key = 4'd3; ukey[6] = 1'b1; fire();
    expect_res("R7 user keys off", 1, 3'd7, 6'h00, 0);
    defaults(); us = 0; sken = 0; skey = '1; fire();
    expect_res("R7 sup keys off", 1, 3'd7, 6'h00, 0);
    defaults(); us = 0; uken = 1; ukey = '1; fire();
    expect_res("R7 sup page ignores ukey", 1, 3'd7, 6'h00, 0);
    defaults(); us = 0; sken = 1; key = 4'd15; skey[31] = 1'b1; acc = 2'd1; fire();
    expect_res("R8 sup wd wp off", 1, 3'd7, 6'h00, 0);
    defaults(); us = 0; sken = 1; key = 4'd15; skey[31] = 1'b1; wp = 1; acc = 2'd1; fire();
    expect_res("R9 sup wd wp on", 0, 3'd0, 6'h23, 0);
    defaults(); user = 1; rw = 0; uken = 1; key = 4'd0; ukey[1] = 1'b1; acc = 2'd1; fire();
    expect_res("R12 key over perm", 0, 3'd0, 6'h27, 0);
  endtask

  task automatic t_hold();
    defaults(); user = 1; us = 0; fire();
    defaults(); us = 0; acc = 2'd1;
    @(negedge clk);
    chk("R1 idle valid", 32'(valid_o), 0);
    chk("R1 idle err held", 32'(err_o), 32'h05);
    chk("R1 idle allow held", 32'(allow_o), 0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_absent();
    t_rsvd();
    t_usr();
    t_rw();
    t_exec();
    t_key();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule